// File: doc/BRIEF.md
# Branch condition evaluator

This block turns a set of four stored status flags (negative, zero, signed overflow, carry) and a 4-bit condition selector into one "take branch" decision. The flags are those that a preceding compare (a subtraction A - B) left behind. Carry follows the no-borrow convention: it is 1 when the subtraction needed no borrow. The selector chooses one comparison from four groups: equality, unsigned ordering, signed ordering, and an unconditional "always".

A combinational path gives the decision in the same cycle. A registered copy is also available. It loads the decision when a valid strobe is high and holds its value on the other cycles. The registered copy lets a fetch stage consume the result one cycle later, with a clean flop boundary in between.

Top module: `brcond_eval`

## Requirements
- R1: Selector 0 (equal) is taken exactly when Z = 1, and selector 1 (not equal) exactly when Z = 0.
- R2: Selector 2 (unsigned higher-or-same) is taken when C = 1, and selector 3 (unsigned lower) when C = 0.
- R3: Selector 4 (unsigned higher) is taken when C = 1 and Z = 0. Selector 5 (unsigned lower-or-same) is taken when C = 0 or Z = 1.
- R4: Selector 6 (signed greater-or-equal) is taken when N equals V, and selector 7 (signed less) when N differs from V.
- R5: Selector 8 (signed greater) is taken when Z = 0 and N equals V. Selector 9 (signed less-or-equal) is taken when Z = 1 or N differs from V.
- R6: Selector 10 is always taken. Selectors 11 to 15 are never taken.
- R7: The combinational output `take_o` depends only on the current flags and selector, within the same cycle.
- R8: `take_q` is 0 after reset. On a clock edge with `valid_i` high it loads the value `take_o` had before that edge. With `valid_i` low it keeps its value.
- R9: Each complementary pair of selectors (0/1, 2/3, 4/5, 6/7, 8/9) gives opposite decisions for every combination of flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered decision |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Signed overflow flag |
| flag_c_i | input | 1 | Carry flag (1 = no borrow) |
| cond_i | input | 4 | Condition selector |
| valid_i | input | 1 | Load strobe for the registered decision |
| take_o | output | 1 | Combinational branch decision |
| take_q | output | 1 | Registered branch decision |

## Verification
The bench derives the flags from 8-bit compares. It includes the pairs where signed and unsigned order disagree (for example 32 against 129, and 127 against -128, where V is set), equal operands, and operands that differ by one. A design that inverted the carry sense would swap higher and lower on every unsigned test. A design that read N alone instead of N xor V would fail on the compares that overflow. A design that dropped Z from the strict conditions would report "greater" on equal operands. Unused selectors and the hold behaviour of the register under a low strobe are each checked directly at the ports.

// File: rtl/brcond_eval.sv
module brcond_eval #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_n_i,
  input  logic          flag_z_i,
  input  logic          flag_v_i,
  input  logic          flag_c_i,
  input  logic [CW-1:0] cond_i,
  input  logic          valid_i,
  output logic          take_o,
  output logic          take_q
);
  logic lt_s, hi_u, gt_s;

  assign lt_s = flag_n_i ^ flag_v_i;
  assign hi_u = flag_c_i & ~flag_z_i;
  assign gt_s = ~flag_z_i & ~lt_s;

  always_comb begin
    case (cond_i)
      CW'(0):  take_o = flag_z_i;
      CW'(1):  take_o = ~flag_z_i;
      CW'(2):  take_o = flag_c_i;
      CW'(3):  take_o = ~flag_c_i;
      CW'(4):  take_o = hi_u;
      CW'(5):  take_o = ~hi_u;
      CW'(6):  take_o = ~lt_s;
      CW'(7):  take_o = lt_s;
      CW'(8):  take_o = gt_s;
      CW'(9):  take_o = ~gt_s;
      CW'(10): take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       take_q <= 1'b0;
    else if (valid_i) take_q <= take_o;
  end
endmodule

module brcond_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_n_i,
  input logic       flag_z_i,
  input logic       flag_v_i,
  input logic       flag_c_i,
  input logic [3:0] cond_i,
  input logic       valid_i,
  input logic       take_o,
  input logic       take_q
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(take_q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> take_q == $past(take_o));
  p_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 4'd10 |-> take_o);
  p_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i > 4'd10 |-> !take_o);
  p_eq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 4'd0 |-> take_o == flag_z_i);
  p_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 4'd3 |-> take_o == !flag_c_i);
  p_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'd4 && flag_z_i) |-> !take_o);
  p_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i == 4'd7 |-> take_o == (flag_n_i != flag_v_i));
  p_gt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'd8 && flag_z_i) |-> !take_o);
endmodule

bind brcond_eval brcond_eval_chk u_chk (.*);

// File: tb/brcond_eval_test.sv
module brcond_eval_test;
  logic clk = 0, rst_n = 0;
  logic fn = 0, fz = 0, fv = 0, fc = 0, valid = 0;
  logic [3:0] cond = 0;
  logic take_o, take_q;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  brcond_eval uut (.clk(clk), .rst_n(rst_n), .flag_n_i(fn), .flag_z_i(fz),
    .flag_v_i(fv), .flag_c_i(fc), .cond_i(cond), .valid_i(valid),
    .take_o(take_o), .take_q(take_q));

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cond=%0d nzvc=%b%b%b%b actual=%b expected=%b",
               req, cond, fn, fz, fv, fc, act, exp);
    end
  endtask

  task automatic set_cmp(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] d;
    d = {1'b0, a} - {1'b0, b};
    fn = d[7];
    fz = (d[7:0] == 0);
    fc = ~d[8];
    fv = (a[7] != b[7]) && (d[7] != a[7]);
  endtask

  task automatic cmp_all(input logic [7:0] a, input logic [7:0] b);
    logic eq, ult, slt;
    eq = (a == b);
    ult = (a < b);
    slt = ($signed(a) < $signed(b));
    set_cmp(a, b);
    for (int k = 0; k < 16; k++) begin
      logic e;
      cond = 4'(k);
      case (k)
        0: e = eq;   1: e = !eq;
        2: e = !ult; 3: e = ult;
        4: e = !ult && !eq; 5: e = ult || eq;
        6: e = !slt; 7: e = slt;
        8: e = !slt && !eq; 9: e = slt || eq;
        10: e = 1'b1;
        default: e = 1'b0;
      endcase
      #1;
      if (k < 2) check("R1", take_o, e);
      else if (k < 4) check("R2", take_o, e);
      else if (k < 6) check("R3", take_o, e);
      else if (k < 8) check("R4", take_o, e);
      else if (k < 10) check("R5", take_o, e);
      else check("R6", take_o, e);
    end
  endtask

  task automatic t_reset();
    #1 check("R8", take_q, 1'b0);
  endtask

  task automatic t_corners();
    cmp_all(8'd32, 8'd129);
    cmp_all(8'd129, 8'd32);
    cmp_all(8'd127, 8'd128);
    cmp_all(8'd128, 8'd127);
    cmp_all(8'd7, 8'd7);
    cmp_all(8'd0, 8'd0);
    cmp_all(8'd7, 8'd8);
    cmp_all(8'd8, 8'd7);
    cmp_all(8'd255, 8'd0);
    cmp_all(8'd0, 8'd255);
    cmp_all(8'd156, 8'd100);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) cmp_all(8'($urandom), 8'($urandom));
  endtask

  task automatic t_pairs();
    for (int f = 0; f < 16; f++) begin
      {fn, fz, fv, fc} = 4'(f);
      for (int p = 0; p < 5; p++) begin
        logic a;
        cond = 4'(2 * p); #1; a = take_o;
        cond = 4'(2 * p + 1); #1;
        check("R9", take_o, ~a);
      end
    end
  endtask

  task automatic t_register();
    @(negedge clk);
    {fn, fz, fv, fc} = 4'b0100; cond = 4'd0; valid = 1;
    @(negedge clk); check("R8", take_q, 1'b1);
    valid = 0; cond = 4'd1;
    @(negedge clk); check("R8", take_q, 1'b1);
    @(negedge clk); check("R8", take_q, 1'b1);
    valid = 1;
    @(negedge clk); check("R8", take_q, 1'b0);
    cond = 4'd15; valid = 0; fz = 0;
    #1 check("R7", take_o, 1'b0);
    cond = 4'd10;
    @(negedge clk); check("R8", take_q, 1'b0);
    valid = 1;
    @(negedge clk); check("R8", take_q, 1'b1);
    valid = 0;
  endtask

  initial begin
    t_reset();
    #12 rst_n = 1;
    t_corners();
    t_random();
    t_pairs();
    t_register();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule